// File: doc/BRIEF.md
# Stack Pointer Bounds Checker

This unit sits beside the load/store address path of a 32-bit processor core. For every memory access it forms the effective address: either the sum of two register operands, or one register operand plus an immediate. The immediate is sign-extended from 16 bits, or it is widened to a full 32 bits when an immediate-prefix word is pending. The unit then checks that address against a programmable stack window, but only when the access names the stack-pointer register (r1) as one of its address operands.

An address outside the inclusive window is a stack violation. In the same cycle as the access strobe, the unit raises a hardware-exception request and a kill signal that stops the memory operation from committing. On the following clock edge it records the faulting address and an exception cause code of 7.

Two special registers hold the window. Special-register number 0x800 holds the low limit and number 0x802 holds the high limit. The core writes them through a move-to-special strobe and reads them back through a combinational move-from-special port. After reset the low limit is 0 and the high limit is all ones, so no access can fault until software narrows the window.

Top module: `spbound_chk`

## Requirements
- R1: After reset the low limit reads 0, the high limit reads 0xFFFFFFFF, the recorded fault address and cause are 0, and no access at any address faults.
- R2: A checked access faults when its effective address is unsigned-below the low limit or unsigned-above the high limit. An address equal to either limit does not fault.
- R3: Only accesses whose first operand index is 1 are checked, plus register-form accesses whose second operand index is 1. An immediate-form access with second index 1 and any other first index is never checked.
- R4: The effective address is ra_val+rb_val in register form. In immediate form it is ra_val plus the 16-bit immediate sign-extended, or ra_val plus {prefix_hi, imm} when the prefix flag is set. The sum wraps modulo 2^32.
- R5: The exception request and the kill output are high combinationally, in the cycle the access strobe is high with a violating checked address, and they are low in every other cycle.
- R6: On the clock edge that ends a violating cycle, the recorded fault address takes the effective address and the cause takes the value 7. Both hold unchanged through every cycle without a violation.
- R7: A move-to strobe with number 0x800 writes the low limit and one with number 0x802 writes the high limit. The new value takes effect from the next cycle, and an access checked in the write cycle uses the old limits.
- R8: A move-from read with number 0x800 or 0x802 returns the matching limit, and any other number returns 0. A move-to strobe with any other number leaves both limits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Load/store access strobe |
| acc_regform | input | 1 | 1: register+register address, 0: register+immediate |
| acc_ra_idx | input | 5 | Index of first address operand register |
| acc_rb_idx | input | 5 | Index of second address operand register |
| acc_ra_val | input | 32 | Value of first operand |
| acc_rb_val | input | 32 | Value of second operand |
| acc_imm | input | 16 | Immediate operand |
| pfx_valid | input | 1 | Immediate prefix pending |
| pfx_hi | input | 16 | Upper immediate half from the prefix |
| mts_valid | input | 1 | Move-to-special strobe |
| mts_sel | input | 14 | Special register number for the write |
| mts_data | input | 32 | Write data |
| mfs_sel | input | 14 | Special register number for the read |
| mfs_data | output | 32 | Read data (combinational) |
| hw_exc | output | 1 | Hardware exception request |
| acc_kill | output | 1 | Suppress the current memory access |
| fault_addr | output | 32 | Last faulting effective address |
| fault_cause | output | 5 | Last exception cause code |

## Verification
The window is exercised at four exact edges: low-1, low, high and high+1. These tell inclusive bounds apart from exclusive or off-by-one compares. Matching out-of-window accesses are sent with r1 as first operand, with r1 as second operand in register form, with r1 as second operand in immediate form, and without r1 at all. This separates the operand-qualification rule from the compare itself. Immediates with the sign bit set, with and without a prefix, confirm the address arithmetic. A limit write in the same cycle as an access shows whether the old or the new limit applies. A long biased random stream around the window, with occasional limit rewrites, is then compared cycle by cycle against the behavioural model.

// File: rtl/spbound_chk.sv
module spbound_chk #(
  parameter int DW        = 32,
  parameter int IDX_W     = 5,
  parameter int SEL_W     = 14,
  parameter int CAUSE_W   = 5,
  parameter int LOW_SEL   = 'h800,
  parameter int HIGH_SEL  = 'h802,
  parameter int SP_IDX    = 1,
  parameter int CAUSE_VAL = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_regform,
  input  logic [IDX_W-1:0]   acc_ra_idx,
  input  logic [IDX_W-1:0]   acc_rb_idx,
  input  logic [DW-1:0]      acc_ra_val,
  input  logic [DW-1:0]      acc_rb_val,
  input  logic [DW/2-1:0]    acc_imm,
  input  logic               pfx_valid,
  input  logic [DW/2-1:0]    pfx_hi,
  input  logic               mts_valid,
  input  logic [SEL_W-1:0]   mts_sel,
  input  logic [DW-1:0]      mts_data,
  input  logic [SEL_W-1:0]   mfs_sel,
  output logic [DW-1:0]      mfs_data,
  output logic               hw_exc,
  output logic               acc_kill,
  output logic [DW-1:0]      fault_addr,
  output logic [CAUSE_W-1:0] fault_cause
);
  localparam int IMM_W = DW / 2;
  localparam logic [SEL_W-1:0] LO_ID = SEL_W'(LOW_SEL);
  localparam logic [SEL_W-1:0] HI_ID = SEL_W'(HIGH_SEL);
  localparam logic [IDX_W-1:0] SP    = IDX_W'(SP_IDX);

  logic [DW-1:0] lo_q, hi_q;
  logic [DW-1:0] op_b, eff_addr;
  logic          uses_sp, out_of_win, viol;

  assign op_b = acc_regform ? acc_rb_val
              : pfx_valid   ? {pfx_hi, acc_imm}
                            : {{IMM_W{acc_imm[IMM_W-1]}}, acc_imm};
  assign eff_addr = acc_ra_val + op_b;

  assign uses_sp    = (acc_ra_idx == SP) || (acc_regform && acc_rb_idx == SP);
  assign out_of_win = (eff_addr < lo_q) || (eff_addr > hi_q);
  assign viol       = acc_valid && uses_sp && out_of_win;

  assign hw_exc   = viol;
  assign acc_kill = viol;

  always_comb begin
    mfs_data = '0;
    if (mfs_sel == LO_ID) mfs_data = lo_q;
    else if (mfs_sel == HI_ID) mfs_data = hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '1;
    end else if (mts_valid) begin
      if (mts_sel == LO_ID) lo_q <= mts_data;
      if (mts_sel == HI_ID) hi_q <= mts_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr  <= '0;
      fault_cause <= '0;
    end else if (viol) begin
      fault_addr  <= eff_addr;
      fault_cause <= CAUSE_W'(CAUSE_VAL);
    end
  end
endmodule

module spbound_chk_sva #(
  parameter int DW = 32, parameter int IDX_W = 5, parameter int SEL_W = 14,
  parameter int CAUSE_W = 5, parameter int LOW_SEL = 'h800,
  parameter int HIGH_SEL = 'h802, parameter int SP_IDX = 1,
  parameter int CAUSE_VAL = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_regform,
  input logic [IDX_W-1:0]   acc_ra_idx,
  input logic [IDX_W-1:0]   acc_rb_idx,
  input logic               mts_valid,
  input logic [SEL_W-1:0]   mts_sel,
  input logic [DW-1:0]      mts_data,
  input logic [SEL_W-1:0]   mfs_sel,
  input logic [DW-1:0]      mfs_data,
  input logic               hw_exc,
  input logic               acc_kill,
  input logic [DW-1:0]      fault_addr,
  input logic [CAUSE_W-1:0] fault_cause,
  input logic [DW-1:0]      lo_q,
  input logic [DW-1:0]      hi_q
);
  a_r5_exc_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hw_exc |-> acc_valid);
  a_r5_kill_with_exc: assert property (@(posedge clk) disable iff (!rst_n)
    hw_exc |-> acc_kill);
  a_r3_sp_operand: assert property (@(posedge clk) disable iff (!rst_n)
    hw_exc |-> (acc_ra_idx == IDX_W'(SP_IDX) ||
                (acc_regform && acc_rb_idx == IDX_W'(SP_IDX))));
  a_r6_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    hw_exc |=> fault_cause == CAUSE_W'(CAUSE_VAL));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_exc |=> ($stable(fault_addr) && $stable(fault_cause)));
  a_r7_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mts_valid && mts_sel == SEL_W'(LOW_SEL)) |=> lo_q == $past(mts_data));
  a_r8_other_sel_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !(mts_valid && (mts_sel == SEL_W'(LOW_SEL) || mts_sel == SEL_W'(HIGH_SEL)))
      |=> ($stable(lo_q) && $stable(hi_q)));
  a_r8_other_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mfs_sel != SEL_W'(LOW_SEL) && mfs_sel != SEL_W'(HIGH_SEL)) |-> mfs_data == '0);
endmodule

bind spbound_chk spbound_chk_sva #(
  .DW(DW), .IDX_W(IDX_W), .SEL_W(SEL_W), .CAUSE_W(CAUSE_W),
  .LOW_SEL(LOW_SEL), .HIGH_SEL(HIGH_SEL), .SP_IDX(SP_IDX), .CAUSE_VAL(CAUSE_VAL)
) u_sva (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_regform(acc_regform),
  .acc_ra_idx(acc_ra_idx), .acc_rb_idx(acc_rb_idx), .mts_valid(mts_valid),
  .mts_sel(mts_sel), .mts_data(mts_data), .mfs_sel(mfs_sel), .mfs_data(mfs_data),
  .hw_exc(hw_exc), .acc_kill(acc_kill), .fault_addr(fault_addr),
  .fault_cause(fault_cause), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/spbound_chk_test.sv
module spbound_chk_test;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_regform = 0, pfx_valid = 0, mts_valid = 0;
  logic [4:0] acc_ra_idx = 0, acc_rb_idx = 0;
  logic [31:0] acc_ra_val = 0, acc_rb_val = 0, mts_data = 0;
  logic [15:0] acc_imm = 0, pfx_hi = 0;
  logic [13:0] mts_sel = 0, mfs_sel = 0;
  logic [31:0] mfs_data, fault_addr;
  logic hw_exc, acc_kill;
  logic [4:0] fault_cause;

  int vectors = 0, errors = 0;
  logic [31:0] m_lo = 0, m_hi = 32'hFFFF_FFFF, m_fa = 0;
  logic [4:0] m_fc = 0;

  always #2.5 clk = ~clk;

  spbound_chk uut (.*);

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(string req);
    logic [31:0] ea, b;
    logic chk, viol, hit_lo, hit_hi;
    #1;
    b = acc_regform ? acc_rb_val : pfx_valid ? {pfx_hi, acc_imm}
                                 : {{16{acc_imm[15]}}, acc_imm};
    ea = acc_ra_val + b;
    chk = (acc_ra_idx == 1) || (acc_regform && acc_rb_idx == 1);
    viol = acc_valid && chk && (ea < m_lo || ea > m_hi);
    hit_lo = (mfs_sel == 14'h800);
    hit_hi = (mfs_sel == 14'h802);
    cmp(req, "hw_exc", 32'(hw_exc), 32'(viol));
    cmp(req, "acc_kill", 32'(acc_kill), 32'(viol));
    cmp(req, "fault_addr", fault_addr, m_fa);
    cmp(req, "fault_cause", 32'(fault_cause), 32'(m_fc));
    cmp(req, "mfs_data", mfs_data, hit_lo ? m_lo : hit_hi ? m_hi : 32'h0);
    @(posedge clk);
    if (viol) begin m_fa = ea; m_fc = 5'd7; end
    if (mts_valid && mts_sel == 14'h800) m_lo = mts_data;
    if (mts_valid && mts_sel == 14'h802) m_hi = mts_data;
    @(negedge clk);
    acc_valid = 0; mts_valid = 0; pfx_valid = 0;
  endtask

  task automatic acc(logic rf, logic [4:0] ri, logic [4:0] bi,
                     logic [31:0] ra, logic [31:0] rb, logic [15:0] im);
    acc_valid = 1; acc_regform = rf; acc_ra_idx = ri; acc_rb_idx = bi;
    acc_ra_val = ra; acc_rb_val = rb; acc_imm = im;
  endtask

  task automatic wr(logic [13:0] s, logic [31:0] d);
    mts_valid = 1; mts_sel = s; mts_data = d;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset values and fully open window
    mfs_sel = 14'h800; cyc("R1");
    mfs_sel = 14'h802; cyc("R1");
    acc(1, 1, 0, 32'h0, 32'h0, 0); cyc("R1");
    acc(1, 1, 0, 32'hFFFF_FFFF, 32'h0, 0); cyc("R1");
    // R7: program window, same-cycle access uses old limits
    wr(14'h800, 32'h1000); acc(1, 1, 0, 32'h0, 32'h0, 0); cyc("R7");
    mfs_sel = 14'h800;
    wr(14'h802, 32'h1FFF); acc(1, 1, 0, 32'h3000, 32'h0, 0); cyc("R7");
    mfs_sel = 14'h802; acc(1, 1, 0, 32'h3000, 32'h0, 0); cyc("R7");
    // R2: inclusive edges
    acc(1, 1, 0, 32'h1000, 0, 0); cyc("R2");
    acc(1, 1, 0, 32'h1FFF, 0, 0); cyc("R2");
    acc(1, 1, 0, 32'h0FFF, 0, 0); cyc("R2");
    acc(1, 1, 0, 32'h2000, 0, 0); cyc("R2");
    // R3: operand qualification
    acc(1, 3, 4, 32'h5000, 0, 0); cyc("R3");
    acc(1, 3, 1, 32'h5000, 32'h4, 0); cyc("R3");
    acc(0, 3, 1, 32'h6000, 0, 16'h0010); cyc("R3");
    acc(0, 1, 7, 32'h6000, 0, 16'h0010); cyc("R3");
    // R4: sign extension and prefix
    acc(0, 1, 0, 32'h1010, 0, 16'hFFF0); cyc("R4");
    acc(0, 1, 0, 32'h1010, 0, 16'hFFEF); cyc("R4");
    acc(0, 1, 0, 32'h1000, 0, 16'h8000); pfx_valid = 1; pfx_hi = 16'h0000; cyc("R4");
    acc(0, 1, 0, 32'h1000, 0, 16'h0FFF); pfx_valid = 1; pfx_hi = 16'h0000; cyc("R4");
    acc(1, 1, 0, 32'hFFFF_F000, 32'h2000, 0); cyc("R4");
    // R5, R6: no strobe, no exception; fault registers hold
    acc(1, 1, 0, 32'h9000, 0, 0); acc_valid = 0; cyc("R5");
    cyc("R6"); cyc("R6");
    // R8: unknown numbers
    wr(14'h801, 32'h0); mfs_sel = 14'h801; cyc("R8");
    mfs_sel = 14'h800; cyc("R8");
    mfs_sel = 14'h802; cyc("R8");
    // Random stream
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      acc(r[0], r[2:1] == 0 ? 5'd1 : 5'(r[3]), r[5:4] == 0 ? 5'd1 : 5'd2,
          32'h0E00 + ($urandom % 32'h1400), $urandom % 32'h300, 16'($urandom));
      acc_valid = r[6] | r[7];
      pfx_valid = r[8] & r[9];
      pfx_hi = r[10] ? 16'hFFFF : 16'h0000;
      mfs_sel = r[12:11] == 0 ? 14'h800 : r[12:11] == 1 ? 14'h802 : 14'(r[31:18]);
      if (r[16:13] == 0) wr(r[17] ? 14'h802 : 14'h800, 32'h0F00 + ($urandom % 32'h1400));
      cyc("R2");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule